// File: doc/BRIEF.md
# Pin Event Bank

This block detects interrupt events on a bank of GPIO pins. The bank is split into ports of eight pins each. Every pin gets a three-bit trigger setting. That setting selects one of five sensing modes: high level, low level, rising edge, falling edge, or any edge. A detected event sets a status bit for that pin.

In edge modes the status bit is sticky. Software drops it by writing a one to the matching bit of a clear vector. In level modes the status bit simply mirrors whether the pin is at its active level. A per-pin enable masks each status bit. The OR of all enabled status bits across every port drives a single bank interrupt line.

The pin inputs are assumed to be already synchronised to `clk_i`. Register decode is done elsewhere. The register values arrive here as plain vectors.

Top module: `pin_event_bank`

## Requirements
- R1: While `rst_ni` is low, every status bit and `irq_o` are 0. The reset acts asynchronously, and the stored previous pin sample also resets to 0.
- R2: The trigger settings of port p sit in `trig_cfg_i[24p+23:24p]`. For pin n of that slice, bit n is the polarity (1 selects high level or rising edge), bit n+8 is the edge-mode flag (1 = edge, 0 = level), and bit n+16 is the any-edge flag. Pin n of port p is bit 8p+n of `pin_i`, `irq_en_i`, `clr_i` and `status_o`.
- R3: Edges are found by comparing the pin with its sample from the previous clock. With edge mode 1 and any-edge 0, a rising edge (polarity 1) or a falling edge (polarity 0) sets the status bit at the same clock edge that samples it. The opposite edge sets nothing.
- R4: With edge mode 1 and any-edge 1, both rising and falling edges set the status bit, whatever the polarity bit holds.
- R5: With edge mode 0, the status bit is a registered copy of (pin == polarity), refreshed every clock. A clear issued while the level is active leaves the bit at 1.
- R6: In edge mode a set status bit stays at 1 for as long as its clear bit is 0.
- R7: A clear bit of 1 on an edge-mode pin with no new edge drops its status bit at the next clock.
- R8: When a qualifying edge and a clear of the same bit fall in the same cycle, the status bit ends up at 1.
- R9: The enable bits affect only `irq_o`. Status bits still record events while their enable is 0.
- R10: `irq_o` is 1 exactly when some bit of `status_o` and the same bit of `irq_en_i` are both 1, in any port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pin_i | input | NUM_PORTS*PORT_W | Synchronised pin levels |
| trig_cfg_i | input | NUM_PORTS*3*PORT_W | Trigger settings, one 24-bit slice per port |
| irq_en_i | input | NUM_PORTS*PORT_W | Per-pin interrupt enables |
| clr_i | input | NUM_PORTS*PORT_W | Write-one-to-clear strobes, valid for one cycle |
| status_o | output | NUM_PORTS*PORT_W | Per-pin event status |
| irq_o | output | 1 | Bank interrupt |

## Verification
The bench builds the block with its defaults: four ports of eight pins. Port 0 carries a mix of all five sensing modes, so every detector variant, the clear-versus-set collision and the level-with-clear case can be exercised on one byte. The other ports use level-high sensing with their pins held low. Port 3 is later switched to rising edge, which reaches the top slice of both the configuration and the status vectors and shows that the bank OR spans every port.

// File: rtl/pev_pkg.sv
package pev_pkg;
  typedef struct packed {
    logic any_edge;
    logic edge_mode;
    logic active_high;
  } trig_t;

  typedef enum logic [1:0] {
    SENSE_LEVEL    = 2'd0,
    SENSE_ONE_EDGE = 2'd1,
    SENSE_ANY_EDGE = 2'd2
  } sense_e;

  function automatic sense_e sense_of(trig_t t);
    if (!t.edge_mode)    return SENSE_LEVEL;
    else if (t.any_edge) return SENSE_ANY_EDGE;
    else                 return SENSE_ONE_EDGE;
  endfunction
endpackage

// File: rtl/pev_pin_cell.sv
module pev_pin_cell
  import pev_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  level_i,
  input  trig_t trig_i,
  input  logic  clr_i,
  output logic  status_o
);
  logic prev_q, status_q, status_d;
  logic rise, fall;

  assign rise = level_i & ~prev_q;
  assign fall = ~level_i & prev_q;

  // set term ORed after the clear term: set wins
  always_comb begin
    case (sense_of(trig_i))
      SENSE_LEVEL:    status_d = (level_i == trig_i.active_high);
      SENSE_ONE_EDGE: status_d = (trig_i.active_high ? rise : fall) | (status_q & ~clr_i);
      default:        status_d = rise | fall | (status_q & ~clr_i);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q   <= 1'b0;
      status_q <= 1'b0;
    end else begin
      prev_q   <= level_i;
      status_q <= status_d;
    end
  end

  assign status_o = status_q;
endmodule

// File: rtl/pev_port.sv
module pev_port
  import pev_pkg::*;
#(
  parameter int PORT_W = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [PORT_W-1:0]     level_i,
  input  logic [3*PORT_W-1:0]   cfg_i,
  input  logic [PORT_W-1:0]     en_i,
  input  logic [PORT_W-1:0]     clr_i,
  output logic [PORT_W-1:0]     status_o,
  output logic                  pend_o
);
  for (genvar n = 0; n < PORT_W; n++) begin : g_pin
    trig_t trig;
    assign trig = '{any_edge:    cfg_i[2*PORT_W+n],
                    edge_mode:   cfg_i[PORT_W+n],
                    active_high: cfg_i[n]};
    pev_pin_cell u_cell (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .level_i  (level_i[n]),
      .trig_i   (trig),
      .clr_i    (clr_i[n]),
      .status_o (status_o[n])
    );
  end

  assign pend_o = |(status_o & en_i);
endmodule

// File: rtl/pin_event_bank.sv
module pin_event_bank #(
  parameter int NUM_PORTS = 4,
  parameter int PORT_W    = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_PORTS*PORT_W-1:0]   pin_i,
  input  logic [NUM_PORTS*3*PORT_W-1:0] trig_cfg_i,
  input  logic [NUM_PORTS*PORT_W-1:0]   irq_en_i,
  input  logic [NUM_PORTS*PORT_W-1:0]   clr_i,
  output logic [NUM_PORTS*PORT_W-1:0]   status_o,
  output logic                          irq_o
);
  localparam int CFG_W = 3 * PORT_W;

  logic [NUM_PORTS-1:0] port_pend;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    pev_port #(.PORT_W(PORT_W)) u_port (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .level_i  (pin_i[p*PORT_W +: PORT_W]),
      .cfg_i    (trig_cfg_i[p*CFG_W +: CFG_W]),
      .en_i     (irq_en_i[p*PORT_W +: PORT_W]),
      .clr_i    (clr_i[p*PORT_W +: PORT_W]),
      .status_o (status_o[p*PORT_W +: PORT_W]),
      .pend_o   (port_pend[p])
    );
  end

  assign irq_o = |port_pend;
endmodule

// File: rtl/pev_checker.sv
module pev_checker #(
  parameter int NUM_PORTS = 4,
  parameter int PORT_W    = 8
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic [NUM_PORTS*PORT_W-1:0]   pin_i,
  input logic [NUM_PORTS*3*PORT_W-1:0] trig_cfg_i,
  input logic [NUM_PORTS*PORT_W-1:0]   irq_en_i,
  input logic [NUM_PORTS*PORT_W-1:0]   clr_i,
  input logic [NUM_PORTS*PORT_W-1:0]   status_o,
  input logic                          irq_o
);
  localparam int CFG_W = 3 * PORT_W;

  logic armed;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  assert_reset_R1: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (status_o == '0 && !irq_o));

  assert_quiet_irq_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status_o & irq_en_i) == '0) |-> !irq_o);

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_p
    for (genvar n = 0; n < PORT_W; n++) begin : g_n
      localparam int B = p*PORT_W + n;
      logic pol, edg, any;
      assign pol = trig_cfg_i[p*CFG_W + n];
      assign edg = trig_cfg_i[p*CFG_W + PORT_W + n];
      assign any = trig_cfg_i[p*CFG_W + 2*PORT_W + n];

      assert_level_follow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !edg |=> (status_o[B] == $past(pin_i[B] == pol)));

      assert_rise_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (armed && edg && !any && pol && $rose(pin_i[B])) |=> status_o[B]);

      assert_fall_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (armed && edg && !any && !pol && $fell(pin_i[B])) |=> status_o[B]);

      assert_any_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (armed && edg && any && !$stable(pin_i[B])) |=> status_o[B]);

      assert_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (edg && status_o[B] && !clr_i[B]) |=> status_o[B]);

      assert_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (armed && edg && clr_i[B] && $stable(pin_i[B])) |=> !status_o[B]);

      assert_set_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (armed && edg && any && clr_i[B] && !$stable(pin_i[B])) |=> status_o[B]);
    end
  end
endmodule

bind pin_event_bank pev_checker #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) u_chk (.*);

// File: tb/sim_pin_event_bank.sv
module sim_pin_event_bank;
  localparam int NP = 4;
  localparam int PW = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NP*PW-1:0]  pin = '0;
  logic [NP*3*PW-1:0] cfg;
  logic [NP*PW-1:0]  en = '0;
  logic [NP*PW-1:0]  clr = '0;
  logic [NP*PW-1:0]  status;
  logic              irq;

  int n_vec = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  pin_event_bank #(.NUM_PORTS(NP), .PORT_W(PW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .trig_cfg_i(cfg),
    .irq_en_i(en), .clr_i(clr), .status_o(status), .irq_o(irq)
  );

  // port 0 pins: 0 rise, 1 fall, 2 any, 3 level high, 4 level low, 5..7 rise
  localparam logic [23:0] P0_CFG = 24'h04E7E9;
  localparam logic [23:0] LVL_HI = 24'h0000FF;
  localparam logic [23:0] RISE_ALL = 24'h00FFFF;

  // {pin, clr, en, exp_status, exp_irq} on port 0
  localparam int NV = 14;
  localparam logic [32:0] VEC [NV] = '{
    {8'h00, 8'h00, 8'h00, 8'h10, 1'b0}, // R5 low level, R9 disabled still records
    {8'h01, 8'h00, 8'h01, 8'h11, 1'b1}, // R3 rise
    {8'h00, 8'h01, 8'h01, 8'h10, 1'b0}, // R7 clear, R3 wrong edge ignored
    {8'h02, 8'h00, 8'hFF, 8'h10, 1'b1}, // R3 rise on falling pin ignored
    {8'h00, 8'h00, 8'h02, 8'h12, 1'b1}, // R3 fall
    {8'h04, 8'h02, 8'h00, 8'h14, 1'b0}, // R4 rise on any-edge, R7
    {8'h00, 8'h04, 8'h00, 8'h14, 1'b0}, // R8 set wins, R4 fall
    {8'h18, 8'h04, 8'h08, 8'h08, 1'b1}, // R5 level high active, low inactive
    {8'h18, 8'h08, 8'h08, 8'h08, 1'b1}, // R5 clear has no lasting effect
    {8'h10, 8'h00, 8'h08, 8'h00, 1'b0}, // R5 level drops
    {8'hF0, 8'h00, 8'h00, 8'hE0, 1'b0}, // R9 record while disabled
    {8'hF0, 8'hA0, 8'h40, 8'h40, 1'b1}, // R7 partial clear
    {8'hF0, 8'h00, 8'h40, 8'h40, 1'b1}, // R6 sticky with zero clear
    {8'hF0, 8'h40, 8'h40, 8'h00, 1'b0}  // R7
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    cfg = {LVL_HI, LVL_HI, LVL_HI, P0_CFG};
    repeat (3) @(negedge clk);
    check("R1 status in reset", status, 32'h0);
    check("R1 irq in reset", {31'h0, irq}, 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      pin = {24'h0, VEC[i][32:25]};
      clr = {24'h0, VEC[i][24:17]};
      en  = {24'h0, VEC[i][16:9]};
      @(negedge clk);
      if ({status, irq} !== {24'h0, VEC[i][8:0]}) begin
        n_bad++;
        $display("FAIL vector %0d: actual %h/%b expected %h/%b",
                 i, status, irq, {24'h0, VEC[i][8:1]}, VEC[i][0]);
      end
      n_vec++;
    end
    clr = '0;

    // R2 R10: top port slice, bank OR across ports
    cfg = {RISE_ALL, LVL_HI, LVL_HI, P0_CFG};
    pin = {8'h80, 16'h0, 8'hF0};
    en  = {8'h80, 24'h0};
    @(negedge clk);
    check("R2 port3 status", status, 32'h8000_0000);
    check("R10 irq from port3", {31'h0, irq}, 32'h1);

    // R9: disabling masks irq only
    en = '0;
    @(negedge clk);
    check("R9 status kept", status, 32'h8000_0000);
    check("R9 irq masked", {31'h0, irq}, 32'h0);

    // R1: asynchronous reset mid-run
    pin = '0;
    #1 rst_n = 1'b0;
    #0.5;
    check("R1 async status", status, 32'h0);
    check("R1 async irq", {31'h0, irq}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R5 after reset", status, 32'h0000_0010);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule